// File: doc/BRIEF.md
# Untagged Branch Direction and Indirect Target Predictor

This block guesses where control flow goes next for two classes of instruction. Conditional branches are handled by a table of two-bit saturating counters that learns a taken/not-taken bias per table slot. Indirect jumps are handled by a second table that remembers the most recent destination seen in each slot. Both tables are selected by a slice of the instruction address just above the word-alignment bits. Neither table stores any tag, so unrelated instructions whose address slices match share one slot and disturb each other on purpose. This keeps storage to the payload alone.

A fetch stage presents an address and an instruction kind on the lookup port. The prediction appears one clock later. The execute stage reports resolved outcomes on the update port: a taken bit for conditional branches and the real destination for indirect jumps. Direct jumps and plain instructions are never predicted, because their targets are known without help, and their updates are dropped. A lookup and an update that land on the same slot in the same cycle see the slot as it was before the update.

Top module: `ctl_flow_predictor`

## Requirements
- R1: After reset every direction counter holds 2, so a conditional lookup predicts taken. Every target slot is empty, so an indirect lookup raises the miss flag and returns a zero target.
- R2: Kind codes are 0 for a conditional branch, 1 for an indirect jump, 2 for a direct jump and 3 for any other instruction. A conditional lookup predicts taken exactly when its counter is 2 or 3. At most one of taken, miss and a nonzero target is ever shown.
- R3: A conditional update with the taken bit at 1 raises the counter by one. With the taken bit at 0 it lowers the counter by one. The counter stays at 3 when raised from 3 and stays at 0 when lowered from 0.
- R4: The slot is address bits [IDX_W+1:2]. Bits [1:0] and all bits above the slice have no effect on which slot is used.
- R5: Two addresses with equal slot bits share one counter and one target slot. An update through one address changes the prediction seen through the other.
- R6: An indirect update writes its destination into the slot and marks the slot filled. A later indirect lookup of that slot returns that destination with the miss flag low, until another indirect update to the slot replaces it.
- R7: Lookups of kind 2 or 3 return taken 0, target 0 and miss 0. Updates of kind 2 or 3 change no counter and no target slot.
- R8: A lookup presented at one clock edge yields pr_valid high and its result in the following cycle. Without a lookup, pr_valid, pr_taken, pr_miss and pr_target are all zero.
- R9: When a lookup and an update address the same slot in one cycle, the lookup result reflects the slot's contents before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | A lookup is requested this cycle |
| lk_pc | input | ADDR_W | Address of the instruction being looked up |
| lk_kind | input | 2 | Kind of the looked-up instruction (codes in R2) |
| up_valid | input | 1 | A resolved outcome is reported this cycle |
| up_pc | input | ADDR_W | Address of the resolved instruction |
| up_kind | input | 2 | Kind of the resolved instruction |
| up_taken | input | 1 | Resolved direction of a conditional branch |
| up_target | input | ADDR_W | Resolved destination of an indirect jump |
| pr_valid | output | 1 | Prediction for last cycle's lookup is present |
| pr_taken | output | 1 | Conditional branch predicted taken |
| pr_miss | output | 1 | Indirect lookup found an empty slot |
| pr_target | output | ADDR_W | Predicted indirect destination |

## Verification
A counter that wraps or sticks shows up as a wrong taken bit on the next lookup of that slot after the offending update. It becomes visible no later than two updates further along, once the counter walks across the 1/2 threshold. A target slot written to the wrong index, or left unfilled, shows up on the next indirect lookup as a stale address or a spurious miss, one cycle after the lookup is issued. A slice taken from the wrong address bits makes aliased addresses disagree, or separate addresses agree, on the very first lookup that follows an update.

// File: rtl/pred_pkg.sv
// Shared kind encoding for the control-flow predictor.
// Assumes the fetch and execute stages use the same two-bit kind code.
package pred_pkg;
    typedef enum logic [1:0] {
        KIND_COND   = 2'd0,
        KIND_IND    = 2'd1,
        KIND_DIRECT = 2'd2,
        KIND_NONE   = 2'd3
    } flow_kind_e;
endpackage

// File: rtl/pred_index.sv
// Slot selector: takes IDX_W address bits starting just above the
// alignment bits. Assumes ALIGN_BITS + IDX_W <= ADDR_W.
module pred_index #(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 11,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] pc,
    output logic [IDX_W-1:0]  idx
);
    localparam int TOP = ALIGN_BITS + IDX_W;

    // Pick the slice; the variant depends on whether alignment bits exist.
    generate
        if (ALIGN_BITS == 0) begin : g_noalign
            assign idx = pc[IDX_W-1:0];
            if (TOP < ADDR_W) begin : g_hi
                logic unused_hi;
                assign unused_hi = ^pc[ADDR_W-1:TOP];
            end
        end else begin : g_align
            logic unused_lo;
            assign idx       = pc[TOP-1:ALIGN_BITS];
            assign unused_lo = ^pc[ALIGN_BITS-1:0];
            if (TOP < ADDR_W) begin : g_hi
                logic unused_hi;
                assign unused_hi = ^pc[ADDR_W-1:TOP];
            end
        end
    endgenerate
endmodule

// File: rtl/dir_ctr_table.sv
// Direction table: one two-bit saturating counter per slot, no tag.
// Read is registered; a write in the same cycle is seen only by later reads.
// Assumes at most one read and one write per cycle.
module dir_ctr_table #(
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_inc
);
    localparam int   DEPTH    = 1 << IDX_W;
    localparam logic [1:0] CTR_INIT = 2'd2;
    localparam logic [1:0] CTR_MAX  = 2'd3;
    localparam logic [1:0] CTR_MIN  = 2'd0;

    logic [1:0] ctr [DEPTH];
    logic [1:0] cur;
    logic [1:0] nxt;

    // Next value of the written counter, clamped at both ends.
    always_comb begin
        cur = ctr[wr_idx];
        nxt = cur;
        if (wr_inc && cur != CTR_MAX)       nxt = cur + 2'd1;
        else if (!wr_inc && cur != CTR_MIN) nxt = cur - 2'd1;
    end

    // Counter storage and registered direction read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ctr[i] <= CTR_INIT;
            rd_taken <= 1'b0;
        end else begin
            if (rd_en) rd_taken <= ctr[rd_idx][1];
            if (wr_en) ctr[wr_idx] <= nxt;
        end
    end

    AST_CTR_HOLD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_inc && ctr[wr_idx] == CTR_MAX) |=> (ctr[$past(wr_idx)] == CTR_MAX)); // R3
    AST_CTR_HOLD_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_inc && ctr[wr_idx] == CTR_MIN) |=> (ctr[$past(wr_idx)] == CTR_MIN)); // R3
endmodule

// File: rtl/tgt_table.sv
// Indirect target table: one destination and a filled flag per slot, no tag.
// Read is registered; a write in the same cycle is seen only by later reads.
module tgt_table #(
    parameter int IDX_W  = 11,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_tgt,
    output logic              rd_hit,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ADDR_W-1:0] tgt [DEPTH];
    logic [DEPTH-1:0]  filled;

    // Target storage, filled flags and registered read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tgt[i] <= '0;
            filled <= '0;
            rd_tgt <= '0;
            rd_hit <= 1'b0;
        end else begin
            if (rd_en) begin
                rd_tgt <= tgt[rd_idx];
                rd_hit <= filled[rd_idx];
            end
            if (wr_en) begin
                tgt[wr_idx]    <= wr_data;
                filled[wr_idx] <= 1'b1;
            end
        end
    end

    AST_TGT_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (filled[$past(wr_idx)] && tgt[$past(wr_idx)] == $past(wr_data))); // R6
endmodule

// File: rtl/ctl_flow_predictor.sv
// Branch direction and indirect target predictor with untagged tables.
// Lookup result appears one cycle after the request; updates take effect
// for lookups issued in later cycles. Direct jumps are not predicted.
module ctl_flow_predictor
    import pred_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int IDX_W      = 11,
    parameter int ALIGN_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_pc,
    input  logic [1:0]        lk_kind,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic [1:0]        up_kind,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target,
    output logic              pr_valid,
    output logic              pr_taken,
    output logic              pr_miss,
    output logic [ADDR_W-1:0] pr_target
);
    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic              ctr_rd_en, ctr_wr_en, tgt_rd_en, tgt_wr_en;
    logic              ctr_taken, tgt_hit;
    logic [ADDR_W-1:0] tgt_val;
    flow_kind_e        lk_k, up_k, kind_q;
    logic              valid_q;

    assign lk_k = flow_kind_e'(lk_kind);
    assign up_k = flow_kind_e'(up_kind);

    pred_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS))
        u_lk_index (.pc(lk_pc), .idx(lk_idx));
    pred_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ALIGN_BITS(ALIGN_BITS))
        u_up_index (.pc(up_pc), .idx(up_idx));

    // Steer requests to the table that owns each kind.
    always_comb begin
        ctr_rd_en = lk_valid && (lk_k == KIND_COND);
        tgt_rd_en = lk_valid && (lk_k == KIND_IND);
        ctr_wr_en = up_valid && (up_k == KIND_COND);
        tgt_wr_en = up_valid && (up_k == KIND_IND);
    end

    dir_ctr_table #(.IDX_W(IDX_W)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_en(ctr_rd_en), .rd_idx(lk_idx), .rd_taken(ctr_taken),
        .wr_en(ctr_wr_en), .wr_idx(up_idx), .wr_inc(up_taken)
    );

    tgt_table #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_tgt (
        .clk(clk), .rst_n(rst_n),
        .rd_en(tgt_rd_en), .rd_idx(lk_idx), .rd_tgt(tgt_val), .rd_hit(tgt_hit),
        .wr_en(tgt_wr_en), .wr_idx(up_idx), .wr_data(up_target)
    );

    // Remember whether a lookup happened and of which kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            kind_q  <= KIND_NONE;
        end else begin
            valid_q <= lk_valid;
            kind_q  <= lk_k;
        end
    end

    // Shape the outputs from the owning table, zero otherwise.
    always_comb begin
        pr_valid  = valid_q;
        pr_taken  = valid_q && (kind_q == KIND_COND) && ctr_taken;
        pr_miss   = valid_q && (kind_q == KIND_IND) && !tgt_hit;
        pr_target = (valid_q && (kind_q == KIND_IND) && tgt_hit) ? tgt_val : '0;
    end

    AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pr_valid); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!pr_taken && !pr_miss && pr_target == '0)); // R8
    AST_UNPREDICTED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind[1]) |=> (!pr_taken && !pr_miss && pr_target == '0)); // R7
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pr_taken, pr_miss, (pr_target != '0)})); // R2
endmodule

// File: tb/ctl_flow_predictor_tb_top.sv
// Bench: small 8-slot configuration, directed corner cases then a long
// pseudo-random sweep, with an arithmetic reference model of both tables.
module ctl_flow_predictor_tb_top;
    localparam int AW = 16;
    localparam int IW = 3;
    localparam int NS = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lk_valid = 1'b0, up_valid = 1'b0, up_taken = 1'b0;
    logic [AW-1:0] lk_pc = '0, up_pc = '0, up_target = '0;
    logic [1:0]    lk_kind = 2'd0, up_kind = 2'd0;
    logic          pr_valid, pr_taken, pr_miss;
    logic [AW-1:0] pr_target;

    int            total = 0, bad = 0, cyc = 0;
    int            m_ctr [NS];
    logic [AW-1:0] m_tgt [NS];
    logic          m_fill[NS];

    always #2.5 clk = ~clk;

    ctl_flow_predictor #(.ADDR_W(AW), .IDX_W(IW), .ALIGN_BITS(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_kind(lk_kind),
        .up_valid(up_valid), .up_pc(up_pc), .up_kind(up_kind),
        .up_taken(up_taken), .up_target(up_target),
        .pr_valid(pr_valid), .pr_taken(pr_taken), .pr_miss(pr_miss),
        .pr_target(pr_target)
    );

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            bad   = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // One cycle: drive at negedge, predict from model, update model, check.
    task automatic step(input logic lv, input logic [AW-1:0] lpc, input logic [1:0] lk,
                        input logic uv, input logic [AW-1:0] upc, input logic [1:0] uk,
                        input logic ut, input logic [AW-1:0] utg, input string req);
        int li, ui;
        logic e_v, e_t, e_m;
        logic [AW-1:0] e_tg;
        lk_valid = lv; lk_pc = lpc; lk_kind = lk;
        up_valid = uv; up_pc = upc; up_kind = uk; up_taken = ut; up_target = utg;
        li   = int'(lpc[IW+1:2]);
        ui   = int'(upc[IW+1:2]);
        e_v  = lv;
        e_t  = lv && lk == 2'd0 && m_ctr[li] >= 2;
        e_m  = lv && lk == 2'd1 && !m_fill[li];
        e_tg = (lv && lk == 2'd1 && m_fill[li]) ? m_tgt[li] : '0;
        if (uv && uk == 2'd0) m_ctr[ui] = ut ? ((m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1)
                                             : ((m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1);
        if (uv && uk == 2'd1) begin m_tgt[ui] = utg; m_fill[ui] = 1'b1; end
        @(negedge clk);
        total = total + 1;
        if (pr_valid !== e_v || pr_taken !== e_t || pr_miss !== e_m || pr_target !== e_tg) begin
            bad = bad + 1;
            $display("FAIL %s: actual v=%b t=%b m=%b tg=%h expected v=%b t=%b m=%b tg=%h",
                     req, pr_valid, pr_taken, pr_miss, pr_target, e_v, e_t, e_m, e_tg);
        end
    endtask

    function automatic logic [AW-1:0] slot_pc(input int s, input int hi, input int lo);
        return AW'((hi << (IW + 2)) | (s << 2) | lo);
    endfunction

    initial begin
        logic [31:0] r;
        for (int i = 0; i < NS; i++) begin m_ctr[i] = 2; m_tgt[i] = '0; m_fill[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every slot, both tables.
        for (int i = 0; i < NS; i++) step(1, slot_pc(i, 0, 0), 2'd0, 0, '0, 2'd0, 0, '0, "R1");
        for (int i = 0; i < NS; i++) step(1, slot_pc(i, 0, 0), 2'd1, 0, '0, 2'd0, 0, '0, "R1");
        // R8: no lookup gives quiet outputs.
        step(0, '0, 2'd0, 0, '0, 2'd0, 0, '0, "R8");

        // R3: walk slot 1 down past zero, then back up across the threshold.
        for (int k = 0; k < 5; k++) step(0, '0, 2'd0, 1, slot_pc(1, 0, 0), 2'd0, 0, '0, "R3");
        step(1, slot_pc(1, 0, 0), 2'd0, 1, slot_pc(1, 0, 0), 2'd0, 1, '0, "R3");
        step(1, slot_pc(1, 0, 0), 2'd0, 1, slot_pc(1, 0, 0), 2'd0, 1, '0, "R3");
        step(1, slot_pc(1, 0, 0), 2'd0, 0, '0, 2'd0, 0, '0, "R3");
        // R3: saturate slot 4 at the top, then one decrement stays taken.
        for (int k = 0; k < 4; k++) step(0, '0, 2'd0, 1, slot_pc(4, 0, 0), 2'd0, 1, '0, "R3");
        step(1, slot_pc(4, 0, 0), 2'd0, 1, slot_pc(4, 0, 0), 2'd0, 0, '0, "R3");
        step(1, slot_pc(4, 0, 0), 2'd0, 1, slot_pc(4, 0, 0), 2'd0, 0, '0, "R3");
        step(1, slot_pc(4, 0, 0), 2'd0, 0, '0, 2'd0, 0, '0, "R2");

        // R6: fill slot 2 and read back; R4: low bits and high bits ignored.
        step(0, '0, 2'd0, 1, slot_pc(2, 0, 0), 2'd1, 0, 16'hBEE0, "R6");
        step(1, slot_pc(2, 0, 0), 2'd1, 0, '0, 2'd0, 0, '0, "R6");
        step(1, slot_pc(2, 0, 3), 2'd1, 0, '0, 2'd0, 0, '0, "R4");
        // R5: alias through a different upper address.
        step(0, '0, 2'd0, 1, slot_pc(2, 5, 1), 2'd1, 0, 16'h1234, "R5");
        step(1, slot_pc(2, 0, 0), 2'd1, 0, '0, 2'd0, 0, '0, "R5");
        step(0, '0, 2'd0, 1, slot_pc(6, 9, 0), 2'd0, 0, '0, "R5");
        step(0, '0, 2'd0, 1, slot_pc(6, 2, 0), 2'd0, 0, '0, "R5");
        step(1, slot_pc(6, 0, 2), 2'd0, 0, '0, 2'd0, 0, '0, "R5");

        // R9: same-slot lookup and update see the old contents.
        step(1, slot_pc(3, 0, 0), 2'd0, 1, slot_pc(3, 0, 0), 2'd0, 0, '0, "R9");
        step(1, slot_pc(3, 0, 0), 2'd0, 0, '0, 2'd0, 0, '0, "R9");
        step(1, slot_pc(5, 0, 0), 2'd1, 1, slot_pc(5, 0, 0), 2'd1, 0, 16'h00C4, "R9");
        step(1, slot_pc(5, 0, 0), 2'd1, 0, '0, 2'd0, 0, '0, "R9");

        // R7: direct and other kinds predict nothing and change nothing.
        step(1, slot_pc(2, 0, 0), 2'd2, 1, slot_pc(0, 0, 0), 2'd2, 0, 16'h7770, "R7");
        step(1, slot_pc(2, 0, 0), 2'd3, 1, slot_pc(7, 0, 0), 2'd3, 0, 16'h5550, "R7");
        step(1, slot_pc(0, 0, 0), 2'd0, 0, '0, 2'd0, 0, '0, "R7");
        step(1, slot_pc(7, 0, 0), 2'd1, 0, '0, 2'd0, 0, '0, "R7");

        // R2: long mixed sweep against the model.
        r = 32'h1ACE_B00C;
        for (int n = 0; n < 1500; n++) begin
            logic [31:0] s;
            r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
            s = r ^ (r >> 7);
            step(r[0], r[17:2], r[19:18], r[20], s[15:0], s[17:16], s[18], {s[29:19], 5'd0}, "R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule